// File: doc/BRIEF.md
# Interrupt Line Router

The router gathers up to 32 level-sensitive interrupt requests from peripherals. It latches each request into a per-source status bit and filters the status through a per-source enable bit. Every source that is pending and enabled is then steered onto one of six processor interrupt lines, numbered 2 to 7, according to a small routing field owned by that source. Any number of sources may share one line. Software therefore reads the enabled-and-pending view to learn which of them fired.

Software uses a single-cycle 32-bit register port. The enable register is written directly. The status register is cleared by writing ones. Four routing registers each hold eight 4-bit fields. A read-only register returns the enabled-and-pending set. In the usual handling sequence, software masks a source while it services it, clears the status, and unmasks the source at the end. A request that is still held high keeps its status bit set.

Each processor line is a registered OR. It reflects the register state at the previous clock edge.

Top module: `irq_line_router`

## Requirements
- R1: After reset (active-low `rst_n`), every register reads zero and all six line outputs are low.
- R2: A write to word address 0 replaces the enable register, where bit n enables source n, and the new value reads back from address 0.
- R3: On every clock edge where source input n is high, status bit n (address 1, bit n) is set.
- R4: A write to address 1 clears status bit n when data bit n is one and source n is low in that cycle. If source n is high in that cycle, the bit stays set. Bits written as zero keep their value.
- R5: Address 6 reads the bitwise AND of the enable and status registers. Writes to address 6 change no register.
- R6: Routing register k sits at address 2+k. Its bits [4j+3:4j] form the field of source 8k+j, and each routing register reads back what was last written to it.
- R7: Output bit i (processor line i+2) is high in the cycle after an edge at which some source was pending, was enabled, and had a field equal to i+2. It is low otherwise. Field values 0, 1 and 8 to 15 drive no line.
- R8: A line stays asserted while at least one of the sources that share it remains pending and enabled, even after the others are cleared.
- R9: Address 7 reads zero, and writes to it change no register.
- R10: Clearing the enable bit of the only source that drives a line lowers that line one cycle after the enable register changes, even while the source stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level interrupt requests, bit n is source n |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| cpu_line_o | output | 6 | Processor lines 2..7, bit i is line i+2 |

## Verification
The bench uses the default parameters: 32 sources, 4-bit fields and six lines starting at line 2. With these values the address map fills every word of the 3-bit address space, including the single unmapped word at 7. The four routing registers cover all field positions, so every field value from 0 to 15 can be written and observed. Random field values therefore exercise both the routed and the unrouted codes, and sparse random requests combined with random enable, clear and routing writes make several sources meet on one line.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    // Decoded register class for one bus address
    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_MASK  = 3'd1,
        SEL_STAT  = 3'd2,
        SEL_ROUTE = 3'd3,
        SEL_PEND  = 3'd4
    } reg_sel_e;

    localparam int ADDR_MASK  = 0;
    localparam int ADDR_STAT  = 1;
    localparam int ADDR_ROUTE = 2;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_wdata,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] status_o
);

    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] status_d;

    assign clr_vec = clr_we ? clr_wdata : '0;

    // A held request wins over a clear in the same cycle
    always_comb begin
        status_d = src_i | (status_o & ~clr_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_o <= '0;
            mask_o   <= '0;
        end else begin
            status_o <= status_d;
            if (mask_we) begin
                mask_o <= mask_wdata;
            end
        end
    end

    assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_o == $past(mask_wdata)));

    assert_level_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(src_i)) == $past(src_i)));

    assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(status_o) & ~$past(src_i)) == '0));

    assert_w1c_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_o) & ~$past(clr_vec) & ~status_o) == '0));

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table #(
    parameter int NUM_SRC = 32,
    parameter int FIELD_W = 4,
    parameter int DATA_W  = 32,
    localparam int PER_REG  = DATA_W / FIELD_W,
    localparam int NUM_RT   = NUM_SRC / PER_REG,
    localparam int RT_IDX_W = (NUM_RT > 1) ? $clog2(NUM_RT) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [RT_IDX_W-1:0]        wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [RT_IDX_W-1:0]        rd_idx,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_SRC*FIELD_W-1:0] fields_o
);

    logic [DATA_W-1:0] route_q [NUM_RT];

    for (genvar k = 0; k < NUM_RT; k++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                route_q[k] <= '0;
            end else if (wr_en && (wr_idx == RT_IDX_W'(k))) begin
                route_q[k] <= wr_data;
            end
        end
        // Register k carries the fields of sources PER_REG*k upward
        assign fields_o[k*DATA_W +: DATA_W] = route_q[k];
    end

    assign rd_data = route_q[rd_idx];

    assert_route_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (route_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
    parameter int NUM_SRC   = 32,
    parameter int FIELD_W   = 4,
    parameter int NUM_LINES = 6,
    parameter int LINE_BASE = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         pend_i,
    input  logic [NUM_SRC*FIELD_W-1:0] fields_i,
    output logic [NUM_LINES-1:0]       lines_o
);

    logic [NUM_LINES-1:0] line_d;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic [NUM_SRC-1:0] match;
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign match[s] = pend_i[s] &&
                (fields_i[s*FIELD_W +: FIELD_W] == FIELD_W'(LINE_BASE + l));
        end
        assign line_d[l] = |match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lines_o <= '0;
        end else begin
            lines_o <= line_d;
        end
    end

    assert_idle_lines_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |=> (lines_o == '0));

endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int FIELD_W   = 4,
    parameter int NUM_LINES = 6,
    parameter int LINE_BASE = 2,
    localparam int DATA_W    = NUM_SRC,
    localparam int PER_REG   = DATA_W / FIELD_W,
    localparam int NUM_RT    = NUM_SRC / PER_REG,
    localparam int RT_IDX_W  = (NUM_RT > 1) ? $clog2(NUM_RT) : 1,
    localparam int ADDR_PEND = ADDR_ROUTE + NUM_RT,
    localparam int ADDR_W    = $clog2(ADDR_PEND + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_i,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] cpu_line_o
);

    reg_sel_e              sel;
    logic [RT_IDX_W-1:0]   rt_idx;
    logic [NUM_SRC-1:0]    mask_q;
    logic [NUM_SRC-1:0]    status_q;
    logic [NUM_SRC-1:0]    pend;
    logic [DATA_W-1:0]     rt_rdata;
    logic [NUM_SRC*FIELD_W-1:0] fields;
    logic                  wr;

    assign wr = bus_en && bus_we;

    always_comb begin
        sel    = SEL_NONE;
        rt_idx = '0;
        if (bus_addr == ADDR_W'(ADDR_MASK)) begin
            sel = SEL_MASK;
        end else if (bus_addr == ADDR_W'(ADDR_STAT)) begin
            sel = SEL_STAT;
        end else if ((bus_addr >= ADDR_W'(ADDR_ROUTE)) &&
                     (bus_addr <  ADDR_W'(ADDR_PEND))) begin
            sel    = SEL_ROUTE;
            rt_idx = RT_IDX_W'(bus_addr - ADDR_W'(ADDR_ROUTE));
        end else if (bus_addr == ADDR_W'(ADDR_PEND)) begin
            sel = SEL_PEND;
        end
    end

    irq_status_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .mask_we    (wr && (sel == SEL_MASK)),
        .mask_wdata (bus_wdata),
        .clr_we     (wr && (sel == SEL_STAT)),
        .clr_wdata  (bus_wdata),
        .mask_o     (mask_q),
        .status_o   (status_q)
    );

    irq_route_table #(.NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr && (sel == SEL_ROUTE)),
        .wr_idx   (rt_idx),
        .wr_data  (bus_wdata),
        .rd_idx   (rt_idx),
        .rd_data  (rt_rdata),
        .fields_o (fields)
    );

    assign pend = mask_q & status_q;

    irq_line_merge #(.NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W),
                     .NUM_LINES(NUM_LINES), .LINE_BASE(LINE_BASE)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend),
        .fields_i (fields),
        .lines_o  (cpu_line_o)
    );

    always_comb begin
        unique case (sel)
            SEL_MASK:  bus_rdata = mask_q;
            SEL_STAT:  bus_rdata = status_q;
            SEL_ROUTE: bus_rdata = rt_rdata;
            SEL_PEND:  bus_rdata = pend;
            default:   bus_rdata = '0;
        endcase
    end

    assert_masked_line_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> (cpu_line_o == '0));

    assert_pend_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (sel == SEL_PEND)) |=> $stable(mask_q));

endmodule

// File: tb/irq_line_router_tb.sv
`timescale 1ns/1ps
module irq_line_router_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  cpu_line_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [31:0] mask_m = '0;
    logic [31:0] stat_m = '0;
    logic [31:0] route_m [4];
    logic [5:0]  line_m = '0;

    always #2.5 clk = ~clk;

    irq_line_router u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_line_o(cpu_line_o)
    );

    function automatic logic [5:0] calc_lines(logic [31:0] m, logic [31:0] s,
                                              logic [31:0] r0, logic [31:0] r1,
                                              logic [31:0] r2, logic [31:0] r3);
        logic [127:0] all;
        logic [5:0] res;
        all = {r3, r2, r1, r0};
        res = '0;
        for (int n = 0; n < 32; n++) begin
            for (int i = 0; i < 6; i++) begin
                if (m[n] && s[n] && (all[n*4 +: 4] == 4'(i + 2))) res[i] = 1'b1;
            end
        end
        return res;
    endfunction

    function automatic logic [31:0] exp_read(logic [2:0] a);
        case (a)
            3'd0: return mask_m;
            3'd1: return stat_m;
            3'd2: return route_m[0];
            3'd3: return route_m[1];
            3'd4: return route_m[2];
            3'd5: return route_m[3];
            3'd6: return mask_m & stat_m;
            default: return '0;
        endcase
    endfunction

    function automatic string addr_tag(logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd6: return "R5";
            3'd7: return "R9";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One bus/source cycle; rtag labels the read check, ltag the line check
    task automatic step(logic [31:0] src, logic en, logic we, logic [2:0] addr,
                        logic [31:0] wd, string rtag, string ltag);
        logic [31:0] clr;
        @(negedge clk);
        src_i = src; bus_en = en; bus_we = we; bus_addr = addr; bus_wdata = wd;
        #1;
        check(ltag, {26'd0, cpu_line_o}, {26'd0, line_m});
        if (en && !we) check(rtag, bus_rdata, exp_read(addr));
        @(posedge clk);
        line_m = calc_lines(mask_m, stat_m, route_m[0], route_m[1], route_m[2], route_m[3]);
        clr = '0;
        if (en && we) begin
            case (addr)
                3'd0: mask_m = wd;
                3'd1: clr = wd;
                3'd2: route_m[0] = wd;
                3'd3: route_m[1] = wd;
                3'd4: route_m[2] = wd;
                3'd5: route_m[3] = wd;
                default: ;
            endcase
        end
        stat_m = src | (stat_m & ~clr);
    endtask

    task automatic rd(logic [31:0] src, logic [2:0] a, string tag, string ltag);
        step(src, 1'b1, 1'b0, a, 32'd0, tag, ltag);
    endtask

    task automatic wr(logic [31:0] src, logic [2:0] a, logic [31:0] d, string ltag);
        step(src, 1'b1, 1'b1, a, d, "R2", ltag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) route_m[k] = '0;
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values on every address and on the lines
        for (int a = 0; a < 8; a++) rd('0, 3'(a), "R1", "R1");

        // R6: routing with the common assignment, read back
        wr('0, 3'd2, 32'h0002_2222, "R7");
        wr('0, 3'd3, 32'h6523_0427, "R7");
        wr('0, 3'd4, 32'h0022_2222, "R7");
        wr('0, 3'd5, 32'h0000_0000, "R7");
        for (int a = 2; a < 6; a++) rd('0, 3'(a), "R6", "R7");

        // R2: enable sources 0, 1, 8 and 12
        wr('0, 3'd0, 32'h0000_1103, "R7");
        rd('0, 3'd0, "R2", "R7");

        // R3/R7: source 8 pulses, line 7 follows and stays (status latched)
        rd(32'h0000_0100, 3'd1, "R3", "R7");
        rd('0, 3'd1, "R3", "R7");
        rd('0, 3'd6, "R5", "R7");

        // R4: clear while the request is still high keeps the bit
        wr(32'h0000_0100, 3'd1, 32'h0000_0100, "R7");
        rd('0, 3'd1, "R4", "R7");
        wr('0, 3'd1, 32'h0000_0100, "R7");
        rd('0, 3'd1, "R4", "R7");
        rd('0, 3'd1, "R4", "R7");

        // R8: sources 0 and 1 share line 2; clear only source 0
        rd(32'h0000_0003, 3'd6, "R5", "R8");
        rd('0, 3'd6, "R5", "R8");
        wr('0, 3'd1, 32'h0000_0001, "R8");
        rd('0, 3'd1, "R4", "R8");
        rd('0, 3'd1, "R4", "R8");

        // R10: mask off source 1 while source 12 is held on line 3
        rd(32'h0000_1000, 3'd1, "R3", "R10");
        wr(32'h0000_1000, 3'd0, 32'h0000_1000, "R10");
        rd(32'h0000_1000, 3'd6, "R5", "R10");
        wr(32'h0000_1000, 3'd0, 32'h0000_0000, "R10");
        rd(32'h0000_1000, 3'd6, "R5", "R10");
        rd(32'h0000_1000, 3'd6, "R5", "R10");

        // R5/R9: writes to the pending and unmapped words are ignored
        wr('0, 3'd6, 32'hFFFF_FFFF, "R7");
        wr('0, 3'd7, 32'hFFFF_FFFF, "R7");
        for (int a = 0; a < 8; a++) rd('0, 3'(a), addr_tag(3'(a)), "R9");

        // Random traffic against the model
        for (int t = 0; t < 6000; t++) begin
            logic [31:0] src;
            logic [31:0] d;
            logic [2:0]  a;
            int op;
            src = $urandom() & $urandom() & $urandom() & $urandom();
            a = 3'($urandom_range(0, 7));
            op = $urandom_range(0, 9);
            d = $urandom();
            if (a >= 3'd2 && a <= 3'd5) begin
                for (int j = 0; j < 8; j++)
                    if ($urandom_range(0, 3) != 0) d[j*4 +: 4] = 4'($urandom_range(2, 7));
            end
            if (op < 5)      rd(src, a, addr_tag(a), "R7");
            else if (op < 8) wr(src, a, d, "R7");
            else             step(src, 1'b0, 1'b0, a, d, "R7", "R7");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule